// File: doc/BRIEF.md
# Prioritising Interrupt Controller with Acknowledge and End-of-Interrupt

This block gathers up to a few dozen interrupt request lines and turns them into one request output per processor. Each source can be configured as level or edge triggered. Each source has a forwarding enable and a priority value. A small register slave interface serves both the distributor settings and a per-processor interface. Accesses to that interface are banked by the number of the processor making the access, so each CPU sees its own control bit, priority mask and acknowledge register.

A processor services an interrupt in two steps. First it reads its acknowledge register. The read returns the best candidate and, as a side effect, marks that source active, so no interface offers it again. When the service routine is finished, the processor writes the same ID to the end-of-interrupt register. A source that was requested again while it was active becomes pending once more and is offered again. Routing uses a fixed per-processor target mask set by a parameter.

Top module: `irqc_top`

## Requirements
- R1: A read of the acknowledge register (offset 0x008) puts read data on the bus one cycle later. When the reading CPU can be signalled, bits [9:0] hold the ID of its best candidate, bits [12:10] hold the reading CPU's number and all other bits are zero. A candidate is a source that is pending, enabled, not active and routed to that CPU. The best candidate is the one with the numerically lowest priority value.
- R2: When several candidates share the lowest priority value, the one with the lowest ID is chosen.
- R3: A candidate can be signalled only when its priority value is strictly below the CPU's priority mask (offset 0x004, bits [PRIO_W-1:0]). If no candidate qualifies, the acknowledge read returns 1023.
- R4: When a CPU's interface enable (offset 0x000, bit 0) is clear, its acknowledge read returns 1023 and its request output stays low.
- R5: An acknowledge read that returns 1023 changes no pending or active state.
- R6: An acknowledge read that returns a valid ID makes that source active, so no interface offers it again. For an edge-triggered source the read also clears its pending bit.
- R7: An end-of-interrupt write (offset 0x00C, ID in bits [9:0]) returns an active source to inactive. If the source was requested again while active, it is left pending and is offered again.
- R8: An end-of-interrupt write that names a source which is not active has no effect.
- R9: Writing a 1 to bit n%32 of the set-enable word at byte offset 0x100 + ((n>>5)<<2) enables source n. Writing 0 changes nothing. Reading that word returns the enables.
- R10: Writing a 1 to bit n%32 of the clear-enable word at 0x180 + ((n>>5)<<2) disables source n. Writing 0 changes nothing.
- R11: The request output of a CPU is high exactly when that CPU's interface is enabled and it has a candidate that can be signalled.
- R12: A source's trigger mode is set by bit n%32 of the word at 0x200 + ((n>>5)<<2), where 1 selects edge. In edge mode a rising edge of the line sets the pending bit and the bit stays set until it is acknowledged. In level mode the pending bit follows the line. In both modes the pending state reflects the line two clock edges after the line changes. Source n's priority is written at 0x400 + 4n.
- R13: After reset all enables, control bits, masks, priorities and pending and active bits are zero, the request outputs are low and read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | NUM_IRQ | Interrupt request lines, one per source |
| bus_cpu_i | input | 3 | Number of the CPU making the access; selects the banked interface registers |
| bus_addr_i | input | 12 | Byte address of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe; on the acknowledge offset it is also the acknowledge |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvalid_o | output | 1 | High the cycle after a read |
| irq_o | output | NUM_CPU | Interrupt request, one per CPU |

## Verification
The bench works through the hard cases one at a time:
- A sweep over every source checks the ID and CPU fields of the acknowledge data. A decoder that mixed up the ID would return the wrong number.
- A full priority ordering uses duplicated priority values and a value equal to the mask. This exposes a wrong tie-break, a mask compared with `<=`, and an acknowledge that failed to remove its pick from later selections.
- A level-triggered source is kept high across acknowledge and end-of-interrupt, and an edge source is re-triggered while it is active. Both must be offered again after end-of-interrupt. A design that cleared pending on end-of-interrupt would lose them.
- An end-of-interrupt write naming a source that is not active must leave the active source unreleased.
- A spurious read on a disabled interface must not consume the interrupt that another CPU then takes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ID_W       = 10;
    localparam int CPUID_W    = 3;
    localparam int PRIO_MAX_W = 8;
    localparam int ADDR_W     = 12;

    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'h3FF;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_PMASK  = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_EOI    = 12'h00C;
    localparam logic [ADDR_W-1:0] BASE_SETEN = 12'h100;
    localparam logic [ADDR_W-1:0] BASE_CLREN = 12'h180;
    localparam logic [ADDR_W-1:0] BASE_EDGE  = 12'h200;
    localparam logic [ADDR_W-1:0] BASE_PRIO  = 12'h400;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_CTRL,
        REG_PMASK,
        REG_ACK,
        REG_EOI,
        REG_SETEN,
        REG_CLREN,
        REG_EDGE,
        REG_PRIO
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t  kind;
        logic [7:0] idx;
    } reg_dec_t;

    typedef struct packed {
        logic                  hit;
        logic [ID_W-1:0]       id;
        logic [PRIO_MAX_W-1:0] prio;
    } pick_t;

    function automatic logic [31:0] ack_word(logic [CPUID_W-1:0] cpu, logic [ID_W-1:0] id);
        return {19'd0, cpu, id};
    endfunction

    function automatic logic [7:0] word_index(logic [ADDR_W-1:0] addr, logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] diff;
        diff = addr - base;
        return diff[9:2];
    endfunction

endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic edge_mode_i,
    input  logic ack_i,
    input  logic eoi_i,
    output logic pend_o,
    output logic act_o
);

    logic line_q;
    logic line_d;
    logic pend_q;
    logic act_q;
    logic rise;

    assign rise = line_q & ~line_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            line_d <= 1'b0;
            pend_q <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            line_q <= line_i;
            line_d <= line_q;
            if (edge_mode_i) begin
                pend_q <= (pend_q & ~ack_i) | rise;
            end else begin
                pend_q <= line_q;
            end
            if (ack_i) begin
                act_q <= 1'b1;
            end else if (eoi_i) begin
                act_q <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;
    assign act_o  = act_q;

    // R6: an acknowledge leaves the source active
    p_ack_activates_r6: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> act_o);

    // R6: edge source acknowledged without a new edge loses its pending bit
    p_edge_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_i && edge_mode_i && !rise) |=> !pend_o);

    // R7: end-of-interrupt on an active source releases it
    p_eoi_releases_r7: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && act_o && !ack_i) |=> !act_o);

    // R8: end-of-interrupt cannot make an inactive source active
    p_eoi_inactive_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !act_o && !ack_i) |=> !act_o);

endmodule

// File: rtl/irqc_prio_select.sv
module irqc_prio_select
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_IRQ-1:0]        cand_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    output pick_t                     pick_o
);

    pick_t             best;
    logic [PRIO_W-1:0] p;

    always_comb begin
        best = '0;
        p    = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            p = prio_i[i*PRIO_W +: PRIO_W];
            if (cand_i[i] && (!best.hit || PRIO_MAX_W'(p) < best.prio)) begin
                best.hit  = 1'b1;
                best.id   = ID_W'(i);
                best.prio = PRIO_MAX_W'(p);
            end
        end
    end

    assign pick_o = best;

    // R2: the reported pick is always one of the candidates
    p_pick_is_candidate_r2: assert property (@(posedge clk) disable iff (rst)
        pick_o.hit |-> ((cand_i >> pick_o.id) & NUM_IRQ'(1)) != '0);

    // R1: a missing pick means there was no candidate at all
    p_no_pick_no_cand_r1: assert property (@(posedge clk) disable iff (rst)
        !pick_o.hit |-> cand_i == '0);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int                           NUM_IRQ     = 32,
    parameter int                           NUM_CPU     = 2,
    parameter int                           PRIO_W      = 4,
    parameter logic [NUM_CPU*NUM_IRQ-1:0]   TARGET_MASK = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IRQ-1:0]  irq_line_i,
    input  logic [CPUID_W-1:0]  bus_cpu_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_wr_i,
    input  logic [31:0]         bus_wdata_i,
    input  logic                bus_rd_i,
    output logic [31:0]         bus_rdata_o,
    output logic                bus_rvalid_o,
    output logic [NUM_CPU-1:0]  irq_o
);

    localparam int EN_WORDS = (NUM_IRQ + 31) / 32;
    localparam int CPU_IW   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    reg_dec_t            dec;
    logic                cpu_ok;
    logic [CPU_IW-1:0]   cpu_idx;

    logic [NUM_CPU-1:0]  ctrl_q;
    logic [PRIO_W-1:0]   pmask_q [NUM_CPU];
    logic [NUM_IRQ-1:0]  en_q;
    logic [NUM_IRQ-1:0]  edge_q;
    logic [PRIO_W-1:0]   prio_q  [NUM_IRQ];
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;

    logic [NUM_IRQ-1:0]  pend_vec;
    logic [NUM_IRQ-1:0]  act_vec;
    logic [NUM_IRQ-1:0]  ack_vec;
    logic [NUM_IRQ-1:0]  eoi_vec;

    pick_t               pick   [NUM_CPU];
    logic [NUM_CPU-1:0]  signal;
    logic                ack_rd;
    logic                ack_valid;
    logic [31:0]         rd_next;
    logic [31:0]         rdata_q;
    logic                rvalid_q;

    // ---------------------------------------------------------------
    // Address decode
    // ---------------------------------------------------------------
    always_comb begin
        dec.kind = REG_NONE;
        dec.idx  = '0;
        if (bus_addr_i == OFF_CTRL) begin
            dec.kind = REG_CTRL;
        end else if (bus_addr_i == OFF_PMASK) begin
            dec.kind = REG_PMASK;
        end else if (bus_addr_i == OFF_ACK) begin
            dec.kind = REG_ACK;
        end else if (bus_addr_i == OFF_EOI) begin
            dec.kind = REG_EOI;
        end else if (bus_addr_i >= BASE_SETEN && bus_addr_i < BASE_SETEN + ADDR_W'(4*EN_WORDS)) begin
            dec.kind = REG_SETEN;
            dec.idx  = word_index(bus_addr_i, BASE_SETEN);
        end else if (bus_addr_i >= BASE_CLREN && bus_addr_i < BASE_CLREN + ADDR_W'(4*EN_WORDS)) begin
            dec.kind = REG_CLREN;
            dec.idx  = word_index(bus_addr_i, BASE_CLREN);
        end else if (bus_addr_i >= BASE_EDGE && bus_addr_i < BASE_EDGE + ADDR_W'(4*EN_WORDS)) begin
            dec.kind = REG_EDGE;
            dec.idx  = word_index(bus_addr_i, BASE_EDGE);
        end else if (bus_addr_i >= BASE_PRIO && bus_addr_i < BASE_PRIO + ADDR_W'(4*NUM_IRQ)) begin
            dec.kind = REG_PRIO;
            dec.idx  = word_index(bus_addr_i, BASE_PRIO);
        end
    end

    assign cpu_ok  = (32'(bus_cpu_i) < NUM_CPU);
    assign cpu_idx = CPU_IW'(bus_cpu_i);

    // ---------------------------------------------------------------
    // Configuration registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= '0;
            edge_q <= '0;
            for (int c = 0; c < NUM_CPU; c++) begin
                pmask_q[c] <= '0;
            end
            for (int i = 0; i < NUM_IRQ; i++) begin
                prio_q[i] <= '0;
            end
        end else if (bus_wr_i) begin
            if (dec.kind == REG_CTRL && cpu_ok) begin
                ctrl_q[cpu_idx] <= bus_wdata_i[0];
            end
            if (dec.kind == REG_PMASK && cpu_ok) begin
                pmask_q[cpu_idx] <= bus_wdata_i[PRIO_W-1:0];
            end
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (dec.idx == 8'(i / 32) && bus_wdata_i[i % 32]) begin
                    if (dec.kind == REG_SETEN) en_q[i] <= 1'b1;
                    if (dec.kind == REG_CLREN) en_q[i] <= 1'b0;
                end
                if (dec.kind == REG_EDGE && dec.idx == 8'(i / 32)) begin
                    edge_q[i] <= bus_wdata_i[i % 32];
                end
                if (dec.kind == REG_PRIO && dec.idx == 8'(i)) begin
                    prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
                end
            end
        end
    end

    // ---------------------------------------------------------------
    // Per-source state
    // ---------------------------------------------------------------
    assign ack_rd    = bus_rd_i && dec.kind == REG_ACK;
    assign ack_valid = ack_rd && cpu_ok && signal[cpu_idx];

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_src
        assign prio_flat[gi*PRIO_W +: PRIO_W] = prio_q[gi];
        assign ack_vec[gi] = ack_valid && pick[cpu_idx].id == ID_W'(gi);
        assign eoi_vec[gi] = bus_wr_i && dec.kind == REG_EOI && bus_wdata_i[ID_W-1:0] == ID_W'(gi);

        irqc_src_cell u_cell (
            .clk         (clk),
            .rst         (rst),
            .line_i      (irq_line_i[gi]),
            .edge_mode_i (edge_q[gi]),
            .ack_i       (ack_vec[gi]),
            .eoi_i       (eoi_vec[gi]),
            .pend_o      (pend_vec[gi]),
            .act_o       (act_vec[gi])
        );
    end

    // ---------------------------------------------------------------
    // Per-CPU selection
    // ---------------------------------------------------------------
    for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
        logic [NUM_IRQ-1:0] cand;
        assign cand = pend_vec & en_q & ~act_vec & TARGET_MASK[gc*NUM_IRQ +: NUM_IRQ];

        irqc_prio_select #(
            .NUM_IRQ (NUM_IRQ),
            .PRIO_W  (PRIO_W)
        ) u_sel (
            .clk    (clk),
            .rst    (rst),
            .cand_i (cand),
            .prio_i (prio_flat),
            .pick_o (pick[gc])
        );

        assign signal[gc] = ctrl_q[gc] && pick[gc].hit &&
                            (pick[gc].prio < PRIO_MAX_W'(pmask_q[gc]));
        assign irq_o[gc]  = signal[gc];
    end

    // ---------------------------------------------------------------
    // Read path
    // ---------------------------------------------------------------
    always_comb begin
        rd_next = '0;
        case (dec.kind)
            REG_CTRL:  if (cpu_ok) rd_next = {31'd0, ctrl_q[cpu_idx]};
            REG_PMASK: if (cpu_ok) rd_next = 32'(pmask_q[cpu_idx]);
            REG_ACK:   rd_next = ack_valid ? ack_word(bus_cpu_i, pick[cpu_idx].id)
                                           : 32'(SPURIOUS_ID);
            REG_SETEN, REG_CLREN: begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    if (dec.idx == 8'(i / 32)) rd_next[i % 32] = en_q[i];
                end
            end
            REG_EDGE: begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    if (dec.idx == 8'(i / 32)) rd_next[i % 32] = edge_q[i];
                end
            end
            REG_PRIO: begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    if (dec.idx == 8'(i)) rd_next = 32'(prio_q[i]);
                end
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd_i;
            if (bus_rd_i) rdata_q <= rd_next;
        end
    end

    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = rvalid_q;

    // R1: at most one source is acknowledged per read
    p_ack_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_vec));

    // R4: a disabled interface answers the acknowledge read with the spurious ID
    p_disabled_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && cpu_ok && !ctrl_q[cpu_idx]) |=> bus_rdata_o[ID_W-1:0] == SPURIOUS_ID);

    // R5: a spurious acknowledge leaves the active set untouched
    p_spurious_keeps_state_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !ack_valid && !bus_wr_i) |=> $stable(act_vec));

    // R1: a valid acknowledge read returns data with a real ID
    p_valid_ack_id_r1: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> (bus_rvalid_o && bus_rdata_o[ID_W-1:0] < ID_W'(NUM_IRQ)));

endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;

    localparam int NIRQ = 32;
    localparam int NCPU = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NIRQ-1:0]   lines = '0;
    logic [2:0]        bus_cpu = '0;
    logic [11:0]       bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NCPU-1:0]   irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irqc_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .irq_line_i   (lines),
        .bus_cpu_i    (bus_cpu),
        .bus_addr_i   (bus_addr),
        .bus_wr_i     (bus_wr),
        .bus_wdata_i  (bus_wdata),
        .bus_rd_i     (bus_rd),
        .bus_rdata_o  (bus_rdata),
        .bus_rvalid_o (bus_rvalid),
        .irq_o        (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] cpu);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cpu = cpu; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [2:0] cpu, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_cpu = cpu; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        lines[n] = 1'b1;
        @(negedge clk);
        lines[n] = 1'b0;
        settle();
    endtask

    function automatic logic [31:0] ackv(input int cpu, input int id);
        return (32'(cpu) << 10) | 32'(id);
    endfunction

    function automatic int prio_of(input int n);
        return (n * 5) % 16;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [NIRQ-1:0] taken;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13: reset state
        check("R13 irq after reset", 32'(irq), 32'd0);
        check("R13 rdata after reset", bus_rdata, 32'd0);
        rd(12'h000, 3'd0, d); check("R13 ctrl after reset", d, 32'd0);
        rd(12'h100, 3'd0, d); check("R13 enables after reset", d, 32'd0);

        // Configure: both interfaces on, mask 15, all sources edge, all enabled
        wr(12'h000, 32'd1, 3'd0);
        wr(12'h000, 32'd1, 3'd1);
        wr(12'h004, 32'd15, 3'd0);
        wr(12'h004, 32'd15, 3'd1);
        wr(12'h200, 32'hFFFF_FFFF, 3'd0);
        wr(12'h100, 32'hFFFF_FFFF, 3'd0);
        rd(12'h100, 3'd0, d); check("R9 set-enable readback", d, 32'hFFFF_FFFF);

        // R1/R6: sweep every source through acknowledge and end-of-interrupt
        for (int n = 0; n < NIRQ; n++) begin
            pulse(n);
            rd(12'h008, 3'(n % 2), d);
            check($sformatf("R1 sweep ack id %0d", n), d, ackv(n % 2, n));
            check($sformatf("R6 sweep irq low after ack %0d", n), 32'(irq), 32'd0);
            wr(12'h00C, 32'(n), 3'(n % 2));
        end

        // R2/R3: priority ordering with duplicates and mask-equal values
        for (int n = 0; n < NIRQ; n++) wr(12'h400 + 12'(4*n), 32'(prio_of(n)), 3'd0);
        @(negedge clk); lines = '1;
        @(negedge clk); lines = '0;
        settle();
        taken = '0;
        for (int k = 0; k < NIRQ; k++) begin
            int best;
            best = -1;
            for (int n = 0; n < NIRQ; n++) begin
                if (!taken[n] && prio_of(n) < 15 && (best < 0 || prio_of(n) < prio_of(best))) best = n;
            end
            rd(12'h008, 3'(k % 2), d);
            if (best < 0) begin
                check($sformatf("R3 ordering step %0d spurious", k), d, 32'd1023);
            end else begin
                check($sformatf("R2 ordering step %0d", k), d, ackv(k % 2, best));
                taken[best] = 1'b1;
            end
        end
        for (int n = 0; n < NIRQ; n++) if (taken[n]) wr(12'h00C, 32'(n), 3'd0);
        check("R3 mask-equal sources not requested", 32'(irq), 32'd0);
        wr(12'h400 + 12'(4*3), 32'd14, 3'd0);
        @(negedge clk);
        rd(12'h008, 3'd0, d); check("R3 priority just below mask", d, ackv(0, 3));
        wr(12'h400 + 12'(4*19), 32'd14, 3'd0);
        @(negedge clk);
        rd(12'h008, 3'd1, d); check("R3 second source below mask", d, ackv(1, 19));
        wr(12'h00C, 32'd3, 3'd0);
        wr(12'h00C, 32'd19, 3'd0);

        // R4/R5/R11: disabled interface
        wr(12'h000, 32'd0, 3'd0);
        pulse(5);
        check("R11 irq only on enabled cpu", 32'(irq), 32'b10);
        rd(12'h008, 3'd0, d); check("R4 disabled cpu spurious", d, 32'd1023);
        rd(12'h008, 3'd1, d); check("R5 spurious read left source pending", d, ackv(1, 5));
        wr(12'h00C, 32'd5, 3'd1);
        wr(12'h000, 32'd1, 3'd0);

        // R9/R10: enable registers
        wr(12'h180, 32'h0000_1000, 3'd0);
        rd(12'h100, 3'd0, d); check("R10 clear-enable bit 12", d, 32'hFFFF_EFFF);
        pulse(12);
        check("R10 disabled source not requested", 32'(irq), 32'd0);
        wr(12'h100, 32'h0000_0000, 3'd0);
        rd(12'h180, 3'd0, d); check("R9 zero write leaves enables", d, 32'hFFFF_EFFF);
        wr(12'h180, 32'h0000_0000, 3'd0);
        rd(12'h100, 3'd0, d); check("R10 zero write leaves enables", d, 32'hFFFF_EFFF);
        wr(12'h100, 32'h0000_1000, 3'd0);
        @(negedge clk);
        check("R9 re-enabled source requested", 32'(irq), 32'b11);
        rd(12'h008, 3'd0, d); check("R9 re-enabled ack", d, ackv(0, 12));
        wr(12'h00C, 32'd12, 3'd0);

        // R7: edge source re-triggered while active
        pulse(20);
        rd(12'h008, 3'd0, d); check("R7 edge first ack", d, ackv(0, 20));
        pulse(20);
        check("R6 active source not offered", 32'(irq), 32'd0);
        wr(12'h00C, 32'd20, 3'd0);
        @(negedge clk);
        check("R7 active and pending returns to pending", 32'(irq), 32'b11);
        rd(12'h008, 3'd1, d); check("R7 edge second ack", d, ackv(1, 20));
        wr(12'h00C, 32'd20, 3'd1);
        @(negedge clk);
        check("R7 inactive after final eoi", 32'(irq), 32'd0);

        // R8/R12: level source
        wr(12'h200, 32'hFFFF_FDFF, 3'd0);
        rd(12'h200, 3'd0, d); check("R12 trigger mode readback", d, 32'hFFFF_FDFF);
        @(negedge clk); lines[9] = 1'b1;
        settle();
        check("R12 level pending requested", 32'(irq), 32'b11);
        rd(12'h008, 3'd0, d); check("R12 level ack", d, ackv(0, 9));
        wr(12'h00C, 32'd10, 3'd0);
        rd(12'h008, 3'd0, d); check("R8 eoi of inactive id ignored", d, 32'd1023);
        wr(12'h00C, 32'd9, 3'd0);
        @(negedge clk);
        check("R7 level still high becomes pending", 32'(irq), 32'b11);
        rd(12'h008, 3'd1, d); check("R7 level re-ack", d, ackv(1, 9));
        @(negedge clk); lines[9] = 1'b0;
        wr(12'h00C, 32'd9, 3'd1);
        settle();
        check("R12 level low not pending", 32'(irq), 32'd0);
        rd(12'h008, 3'd0, d); check("R12 level low spurious", d, 32'd1023);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule